// File: doc/BRIEF.md
# Processor Sleep Clock Power Controller

This controller sits next to an embedded processor core and stops the core clock when software asks the core to sleep. The core raises a sleep request once its wait-state enable bit is set and all earlier instructions and memory accesses have finished. The controller answers by gating the core clock, modelled here as a synchronous clock enable. It also reports that the core is asleep. It re-enables the clock when a qualifying wake event arrives.

The core withdraws its external-enable, critical-enable and timer-request outputs one cycle before it withdraws the sleep request. For that reason the controller keeps its own registered snapshot of these three signals. The snapshot follows the core every cycle while running and freezes once sleep begins. The wake decisions use the frozen snapshot.

The wake events are:
- the snapshot timer request, which is the OR of the interval, fixed-interval and watchdog timers;
- the live watchdog reset request;
- a system external interrupt, gated by the snapshot external enable;
- a system critical interrupt, gated by the snapshot critical enable.

The state machine has three states:
- `ST_RUN`: the clock runs and the snapshot tracks the core.
- `ST_SLEEP`: the clock is gated and the snapshot is frozen.
- `ST_WAKE`: the clock runs again and the snapshot is still frozen.

It has four transitions:
- **enter**: `ST_RUN` goes to `ST_SLEEP` when the sleep request rises, meaning it is high in this cycle and was low in the previous one.
- **rouse**: `ST_SLEEP` goes to `ST_WAKE` when any wake event is present.
- **release**: `ST_WAKE` goes to `ST_RUN` once the sleep request is low.
- **stay**: every state holds otherwise.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `core_clk_en` is 1 and `core_asleep` is 0.
- R2: In `ST_RUN`, a sleep request that is high in a cycle after being low in the previous cycle drives `core_clk_en` to 0 and `core_asleep` to 1 after the next clock edge. Interrupt and watchdog inputs have no effect in `ST_RUN`.
- R3: A timer request that is high in the cycle of sleep entry wakes the core. `core_clk_en` returns to 1 one cycle after sleep begins, even if the live timer input has dropped by then.
- R4: While asleep, changes on the core's external-enable, critical-enable and timer-request inputs have no effect. The clock stays gated when they rise after entry.
- R5: A watchdog reset request seen in `ST_SLEEP` wakes the core. `core_clk_en` becomes 1 after the next edge, whatever the snapshot holds.
- R6: A system external interrupt wakes the core from `ST_SLEEP` only if the external enable was 1 in the entry cycle. Otherwise the clock stays gated.
- R7: A system critical interrupt wakes the core from `ST_SLEEP` only if the critical enable was 1 in the entry cycle. Otherwise the clock stays gated.
- R8: After a wake, the clock stays enabled while the sleep request stays high. The controller returns to `ST_RUN` after the first cycle with the request low. A new sleep then needs a fresh rising request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| core_sleep_req | input | 1 | Core asks to be put to sleep |
| core_ext_en | input | 1 | Core external-interrupt enable status |
| core_crit_en | input | 1 | Core critical-interrupt enable status |
| core_timer_irq | input | 1 | Core timer interrupt request (OR of three timers) |
| core_wdog_rst_req | input | 1 | Core watchdog reset request |
| sys_ext_irq | input | 1 | System external interrupt line |
| sys_crit_irq | input | 1 | System critical interrupt line |
| core_clk_en | output | 1 | Synchronous enable for the core clock |
| core_asleep | output | 1 | High while the core clock is gated |

## Verification
Sleep entry and wake qualification can fall in the same cycle. A qualified interrupt, or a high timer request, can already be present on the edge that takes the controller into `ST_SLEEP`. The bench raises the sleep request together with the external enable and an external interrupt. It expects exactly one gated cycle followed by a wake, and also expects no effect at all while in `ST_RUN`. A second overlap is a core that drops its enable bits while the interrupt arrives. There the frozen snapshot must still decide the wake.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } slp_state_t;

    typedef struct packed {
        logic ext_en;
        logic crit_en;
        logic timer;
    } slp_snap_t;
endpackage

// File: rtl/slp_status_latch.sv
module slp_status_latch
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slp_state_t state,
    input  logic       ext_en,
    input  logic       crit_en,
    input  logic       timer,
    output slp_snap_t  snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (state == ST_RUN) begin
            snap.ext_en  <= ext_en;
            snap.crit_en <= crit_en;
            snap.timer   <= timer;
        end
    end

    // R4: snapshot is frozen outside ST_RUN
    assert_snap_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(snap));
endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
(
    input  slp_snap_t snap,
    input  logic      wdog_req,
    input  logic      ext_irq,
    input  logic      crit_irq,
    output logic      wake
);
    logic ext_hit;
    logic crit_hit;

    always_comb begin
        ext_hit  = snap.ext_en & ext_irq;
        crit_hit = snap.crit_en & crit_irq;
        wake     = snap.timer | wdog_req | ext_hit | crit_hit;
    end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake,
    output slp_state_t state,
    output logic       clk_en,
    output logic       asleep
);
    slp_state_t state_d;
    logic       req_prev;
    logic       req_rise;

    assign req_rise = sleep_req & ~req_prev;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:   if (req_rise)   state_d = ST_SLEEP;
            ST_SLEEP: if (wake)       state_d = ST_WAKE;
            ST_WAKE:  if (!sleep_req) state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            req_prev <= 1'b0;
        end else begin
            state    <= state_d;
            req_prev <= sleep_req;
        end
    end

    always_comb begin
        clk_en = 1'b1;
        asleep = 1'b0;
        unique case (state)
            ST_RUN:   clk_en = 1'b1;
            ST_SLEEP: begin
                clk_en = 1'b0;
                asleep = 1'b1;
            end
            ST_WAKE:  clk_en = 1'b1;
            default:  clk_en = 1'b1;
        endcase
    end

    // R3: any qualified wake event leaves sleep on the next edge
    assert_wake_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake) |=> (state == ST_WAKE));

    // R6: without a qualified event the clock stays gated
    assert_no_spurious_wake_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake) |=> (state == ST_SLEEP));

    // R8: wake holds while the request stays high
    assert_hold_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && sleep_req) |=> (state == ST_WAKE));

    // R8: no direct return from wake into sleep
    assert_no_resleep_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |=> (state != ST_SLEEP));
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic core_sleep_req,
    input  logic core_ext_en,
    input  logic core_crit_en,
    input  logic core_timer_irq,
    input  logic core_wdog_rst_req,
    input  logic sys_ext_irq,
    input  logic sys_crit_irq,
    output logic core_clk_en,
    output logic core_asleep
);
    slp_state_t state;
    slp_snap_t  snap;
    logic       wake;

    slp_status_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .ext_en  (core_ext_en),
        .crit_en (core_crit_en),
        .timer   (core_timer_irq),
        .snap    (snap)
    );

    slp_wake_qual u_qual (
        .snap     (snap),
        .wdog_req (core_wdog_rst_req),
        .ext_irq  (sys_ext_irq),
        .crit_irq (sys_crit_irq),
        .wake     (wake)
    );

    slp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (core_sleep_req),
        .wake      (wake),
        .state     (state),
        .clk_en    (core_clk_en),
        .asleep    (core_asleep)
    );

    // R5: a watchdog reset request always ends sleep
    assert_wdog_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (core_asleep && core_wdog_rst_req) |=> core_clk_en);

    // R2: sleep begins only on a rising request
    assert_enter_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(core_asleep) |-> $past(core_sleep_req));
endmodule

// File: tb/test_sleep_clk_ctrl.sv
module test_sleep_clk_ctrl;
    localparam int PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 0, ext_en = 0, crit_en = 0, tmr = 0, wd = 0, xirq = 0, cirq = 0;
    logic clk_en, asleep;

    typedef struct {
        logic  en;
        logic  sl;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    always #(PERIOD/2) clk = ~clk;

    sleep_clk_ctrl i_sleep_clk_ctrl (
        .clk               (clk),
        .rst               (rst),
        .core_sleep_req    (req),
        .core_ext_en       (ext_en),
        .core_crit_en      (crit_en),
        .core_timer_irq    (tmr),
        .core_wdog_rst_req (wd),
        .sys_ext_irq       (xirq),
        .sys_crit_irq      (cirq),
        .core_clk_en       (clk_en),
        .core_asleep       (asleep)
    );

    // Driver: apply inputs at negedge, expect the outputs after the next posedge
    task automatic step(input logic r, input logic ee, input logic ce, input logic t,
                        input logic w, input logic xi, input logic ci,
                        input logic e_en, input logic e_sl, input string tag);
        exp_t item;
        @(negedge clk);
        req = r; ext_en = ee; crit_en = ce; tmr = t; wd = w; xirq = xi; cirq = ci;
        item.en = e_en; item.sl = e_sl; item.tag = tag;
        q.push_back(item);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (clk_en !== e.en || asleep !== e.sl) begin
                n_fail++;
                $display("FAIL %s: clk_en=%0b asleep=%0b expected clk_en=%0b asleep=%0b",
                         e.tag, clk_en, asleep, e.en, e.sl);
            end
        end
    end

    initial begin
        // R1 reset
        step(0,0,0,0,0,0,0, 1,0, "R1 reset");
        step(0,0,0,0,0,0,0, 1,0, "R1 reset");
        @(negedge clk); rst = 1'b0;
        step(0,0,0,0,0,0,0, 1,0, "R1 after reset");
        // R2: events in run have no effect
        step(0,1,1,1,1,1,1, 1,0, "R2 run ignores events");
        step(0,0,0,0,0,0,0, 1,0, "R2 idle");
        // R3: timer at entry
        step(1,0,0,1,0,0,0, 0,1, "R2 enter sleep");
        step(1,0,0,0,0,0,0, 1,0, "R3 latched timer wake");
        step(1,0,0,0,0,0,0, 1,0, "R8 hold wake");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        // R4/R6 masked, R5 watchdog
        step(1,0,0,0,0,0,0, 0,1, "R2 enter sleep");
        step(1,1,0,1,0,1,0, 0,1, "R4 frozen snapshot");
        step(1,1,0,1,0,1,0, 0,1, "R6 masked external");
        step(1,0,0,0,1,0,0, 1,0, "R5 watchdog wake");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        // R6 enabled, core drops enable
        step(1,1,0,0,0,0,0, 0,1, "R2 enter sleep");
        step(1,0,0,0,0,0,0, 0,1, "R4 core drops enable");
        step(1,0,0,0,0,1,0, 1,0, "R6 qualified external");
        step(1,0,0,0,0,0,0, 1,0, "R8 no resleep");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        // R7 masked then enabled
        step(1,0,0,0,0,0,0, 0,1, "R2 enter sleep");
        step(1,0,0,0,0,0,1, 0,1, "R7 masked critical");
        step(1,0,1,0,0,0,1, 0,1, "R7 late enable ignored");
        step(1,0,0,0,1,0,0, 1,0, "R5 watchdog wake");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        step(1,0,1,0,0,0,0, 0,1, "R2 enter sleep");
        step(1,0,0,0,0,0,1, 1,0, "R7 qualified critical");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        // Wake event coincident with entry
        step(1,1,0,0,0,1,0, 0,1, "R2 enter with irq");
        step(1,1,0,0,0,1,0, 1,0, "R6 immediate wake");
        step(1,0,0,0,0,0,0, 1,0, "R8 hold wake");
        step(1,0,0,0,0,0,0, 1,0, "R8 hold wake");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        step(1,0,0,0,0,0,0, 0,1, "R8 fresh rise sleeps");
        step(1,0,0,0,1,0,0, 1,0, "R5 watchdog wake");
        step(0,0,0,0,0,0,0, 1,0, "R8 release");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule